// File: doc/BRIEF.md
# Duplicated Operand Register File

This block is the operand-supply stage of a simple pipelined datapath. It holds 32 general registers of 32 bits. The storage is built as two identical copies that are always written together. Each copy has one combinational read port, so two source registers can be fetched in the same cycle without a multi-port array. Copy A feeds the first operand and copy B feeds the second.

Each operand has its own two-way select, and the selected value is captured in an operand register on the rising clock edge. The first operand can take the value now being written back instead of the stored one. This forwarding happens automatically when the write hits the register being read, and a control field can force it on or off. The second operand can take a 16-bit immediate from the instruction, sign-extended to 32 bits, instead of the copy-B read. The ALU, instruction decode and memory interface sit outside this block and drive its inputs.

Top module: `dup_operand_rf`

## Requirements
- R1: When `wr_en` is 1 at a rising edge, `wr_data` is stored at `wr_addr`. From the next cycle on, that value reaches either operand through an array read.
- R2: Every write updates both copies. Reading one address on both ports (with `imm_sel`=0 and `fwd_ctl`=1) gives equal operands.
- R3: With `fwd_ctl` equal to 0 or 3, `wr_en`=1 and `wr_addr`==`rd_addr_a`, `opnd_a` after the edge equals that cycle's `wr_data`.
- R4: With `fwd_ctl`=2, `opnd_a` after the edge equals that cycle's `wr_data`, whatever `wr_en` and the addresses are.
- R5: With `fwd_ctl`=1, `opnd_a` takes the copy-A read. A read and a write to the same address in one cycle give the value stored before the write.
- R6: The B path never forwards. With `imm_sel`=0 and a same-cycle write to `rd_addr_b`, `opnd_b` gets the old stored value.
- R7: With `imm_sel`=1, `opnd_b` after the edge equals `imm16` sign-extended, with bit 15 copied into bits 31:16.
- R8: Register 0 is ordinary storage and reads back whatever was last written to it.
- R9: While `rst_n` is 0, both operand registers hold 0.
- R10: A cycle with `wr_en`=0 changes no stored register and forwards nothing in automatic mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the operand registers |
| wr_en | input | 1 | Write-back enable |
| wr_addr | input | 5 | Write-back register index |
| wr_data | input | 32 | Write-back value from the latched result bus |
| rd_addr_a | input | 5 | Copy-A read index (first operand) |
| rd_addr_b | input | 5 | Copy-B read index (second operand) |
| fwd_ctl | input | 2 | First-operand select: 0/3 automatic, 1 array only, 2 forward always |
| imm_sel | input | 1 | 1 selects the extended immediate for the second operand |
| imm16 | input | 16 | Instruction immediate |
| opnd_a | output | 32 | Registered first operand |
| opnd_b | output | 32 | Registered second operand |

## Verification
Both operands come out of exactly one register. The inputs of cycle n show up on `opnd_a` and `opnd_b` just after edge n+1. A write made at edge n+1 is seen through the array only by reads issued in cycle n+1 or later. The bench drives inputs on the falling edge and computes the expected operands from its model before the rising edge. It updates the model at the rising edge and compares at the next falling edge. Because the model is updated only after the prediction, the old-value cases (R5, R6) and the forwarded-value cases (R3, R4) line up with the single register stage.

// File: rtl/opf_pkg.sv
`timescale 1ns/1ps
package opf_pkg;
   typedef enum logic [1:0] {
      FWD_AUTO     = 2'd0,
      FWD_ARRAY    = 2'd1,
      FWD_RESULT   = 2'd2,
      FWD_AUTO_ALT = 2'd3
   } fwd_ctl_e;
endpackage

// File: rtl/rf_bank.sv
`timescale 1ns/1ps
module rf_bank #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 32,
   parameter int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

   // R1: a write is visible in the array after the edge
   a_r1_store: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> mem[$past(waddr)] == $past(wdata));

   // R10: no write enable, no change at the addressed entry
   a_r10_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> mem[$past(waddr)] == $past(mem[waddr]));
endmodule

// File: rtl/opnd_stage.sv
`timescale 1ns/1ps
module opnd_stage #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_alt,
   input  logic [DATA_W-1:0] main_d,
   input  logic [DATA_W-1:0] alt_d,
   output logic [DATA_W-1:0] q
);
   logic [DATA_W-1:0] pick;

   always_comb pick = sel_alt ? alt_d : main_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= pick;
   end

   // R9: operand register cleared while reset is held
   a_r9_reset_clear: assert property (@(posedge clk)
      !rst_n |-> q == '0);
endmodule

// File: rtl/dup_operand_rf.sv
`timescale 1ns/1ps
module dup_operand_rf
   import opf_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int DEPTH        = 32,
   parameter int IMM_W        = 16,
   parameter bit SIGN_EXT_IMM = 1'b1,
   localparam int ADDR_W      = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr_a,
   input  logic [ADDR_W-1:0] rd_addr_b,
   input  logic [1:0]        fwd_ctl,
   input  logic              imm_sel,
   input  logic [IMM_W-1:0]  imm16,
   output logic [DATA_W-1:0] opnd_a,
   output logic [DATA_W-1:0] opnd_b
);
   localparam int NUM_COPIES = 2;
   localparam int EXT_W      = DATA_W - IMM_W;

   if (IMM_W >= DATA_W) begin : g_chk_imm
      $error("IMM_W must be narrower than DATA_W");
   end
   if (DEPTH < 2 || (1 << ADDR_W) != DEPTH) begin : g_chk_depth
      $error("DEPTH must be a power of two of at least 2");
   end

   logic [ADDR_W-1:0] rd_idx [NUM_COPIES];
   logic [DATA_W-1:0] rd_val [NUM_COPIES];

   assign rd_idx[0] = rd_addr_a;
   assign rd_idx[1] = rd_addr_b;

   for (genvar c = 0; c < NUM_COPIES; c++) begin : g_copy
      rf_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_bank (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (wr_en),
         .waddr (wr_addr),
         .wdata (wr_data),
         .raddr (rd_idx[c]),
         .rdata (rd_val[c])
      );
   end

   logic     fwd_hit;
   logic     fwd_sel;
   fwd_ctl_e ctl;

   assign ctl     = fwd_ctl_e'(fwd_ctl);
   assign fwd_hit = wr_en && (wr_addr == rd_addr_a);

   always_comb begin
      unique case (ctl)
         FWD_ARRAY:  fwd_sel = 1'b0;
         FWD_RESULT: fwd_sel = 1'b1;
         default:    fwd_sel = fwd_hit;
      endcase
   end

   logic [DATA_W-1:0] imm_ext;
   if (SIGN_EXT_IMM) begin : g_sext
      assign imm_ext = {{EXT_W{imm16[IMM_W-1]}}, imm16};
   end else begin : g_zext
      assign imm_ext = {{EXT_W{1'b0}}, imm16};
   end

   opnd_stage #(.DATA_W(DATA_W)) u_stage_a (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_alt (fwd_sel),
      .main_d  (rd_val[0]),
      .alt_d   (wr_data),
      .q       (opnd_a)
   );

   opnd_stage #(.DATA_W(DATA_W)) u_stage_b (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_alt (imm_sel),
      .main_d  (rd_val[1]),
      .alt_d   (imm_ext),
      .q       (opnd_b)
   );

   // R2: both copies hold the same value at a freshly written entry
   a_r2_mirror: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> g_copy[0].u_bank.mem[$past(wr_addr)] ==
                g_copy[1].u_bank.mem[$past(wr_addr)]);

   // R3: automatic forward on address match
   a_r3_auto_fwd: assert property (@(posedge clk) disable iff (!rst_n)
      ((fwd_ctl == 2'd0 || fwd_ctl == 2'd3) && wr_en && wr_addr == rd_addr_a)
      |=> opnd_a == $past(wr_data));

   // R4: forced forward
   a_r4_force_fwd: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_ctl == 2'd2) |=> opnd_a == $past(wr_data));

   // R7: immediate path with sign extension
   a_r7_imm: assert property (@(posedge clk) disable iff (!rst_n)
      imm_sel |=> opnd_b[IMM_W-1:0] == $past(imm16) &&
                  (SIGN_EXT_IMM == 1'b0 ||
                   opnd_b[DATA_W-1:IMM_W] == {EXT_W{$past(imm16[IMM_W-1])}}));
endmodule

// File: tb/sim_dup_operand_rf.sv
`timescale 1ns/1ps
module sim_dup_operand_rf;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [4:0]  rd_addr_a = '0;
   logic [4:0]  rd_addr_b = '0;
   logic [1:0]  fwd_ctl = '0;
   logic        imm_sel = 1'b0;
   logic [15:0] imm16 = '0;
   logic [31:0] opnd_a;
   logic [31:0] opnd_b;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;
   logic [31:0] model [32];

   always #2.5 clk = ~clk;

   dup_operand_rf u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
      .fwd_ctl(fwd_ctl), .imm_sel(imm_sel), .imm16(imm16),
      .opnd_a(opnd_a), .opnd_b(opnd_b)
   );

   function automatic logic [31:0] exp_a();
      if (fwd_ctl == 2'd1) return model[rd_addr_a];
      if (fwd_ctl == 2'd2) return wr_data;
      if (wr_en && wr_addr == rd_addr_a) return wr_data;
      return model[rd_addr_a];
   endfunction

   function automatic string tag_a();
      if (fwd_ctl == 2'd2) return "R4";
      if (fwd_ctl == 2'd1) return (wr_en && wr_addr == rd_addr_a) ? "R5" : "R1";
      if (wr_en && wr_addr == rd_addr_a) return "R3";
      return (rd_addr_a == 5'd0) ? "R8" : "R1";
   endfunction

   function automatic logic [31:0] exp_b();
      if (imm_sel) return {{16{imm16[15]}}, imm16};
      return model[rd_addr_b];
   endfunction

   function automatic string tag_b();
      if (imm_sel) return "R7";
      if (wr_en && wr_addr == rd_addr_b) return "R6";
      return "R2";
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // one clock: predict, clock, update model, compare at falling edge
   task automatic step();
      logic [31:0] ea = exp_a();
      logic [31:0] eb = exp_b();
      string ta = tag_a();
      string tb = tag_b();
      logic we = wr_en;
      logic [4:0] wa = wr_addr;
      logic [31:0] wd = wr_data;
      @(posedge clk);
      if (we) model[wa] = wd;
      @(negedge clk);
      chk(ta, opnd_a, ea);
      chk(tb, opnd_b, eb);
   endtask

   task automatic drive(bit we, logic [4:0] wa, logic [31:0] wd,
                        logic [4:0] ra, logic [4:0] rb, logic [1:0] fc,
                        bit is, logic [15:0] im);
      wr_en = we; wr_addr = wa; wr_data = wd; rd_addr_a = ra;
      rd_addr_b = rb; fwd_ctl = fc; imm_sel = is; imm16 = im;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1995));
      repeat (3) @(negedge clk);
      // R9: reset state
      chk("R9", opnd_a, 32'h0);
      chk("R9", opnd_b, 32'h0);
      rst_n = 1'b1;

      // fill all registers; forced forward and immediates keep checks defined
      for (int i = 0; i < 32; i++) begin
         drive(1'b1, 5'(i), 32'hA5000000 ^ (32'(i) * 32'h01010101), 5'(31 - i), 5'(i),
               2'd2, 1'b1, (i % 2) ? 16'h8000 + 16'(i) : 16'h7F00 + 16'(i));
         step();
      end

      // R8 and R2: register 0 on both ports through the array
      drive(1'b0, 5'd3, 32'h0, 5'd0, 5'd0, 2'd1, 1'b0, 16'h0);
      step();
      chk("R2", opnd_a, opnd_b);
      drive(1'b1, 5'd0, 32'hDEADBEEF, 5'd1, 5'd2, 2'd0, 1'b0, 16'h0);
      step();
      drive(1'b0, 5'd0, 32'h0, 5'd0, 5'd0, 2'd0, 1'b0, 16'h0);
      step();
      chk("R8", opnd_a, 32'hDEADBEEF);

      // R3 / R6: same-cycle write and read of reg 7 in automatic mode
      drive(1'b1, 5'd7, 32'h12345678, 5'd7, 5'd7, 2'd3, 1'b0, 16'h0);
      step();
      chk("R3", opnd_a, 32'h12345678);
      // R5: array-only mode returns the old value of reg 9
      drive(1'b1, 5'd9, 32'hCAFEF00D, 5'd9, 5'd9, 2'd1, 1'b0, 16'h0);
      step();
      // R1: the new value reaches both ports next cycle
      drive(1'b0, 5'd9, 32'h0, 5'd9, 5'd9, 2'd0, 1'b0, 16'h0);
      step();
      chk("R1", opnd_b, 32'hCAFEF00D);
      // R10: disabled write with matching address: no forward, no store
      drive(1'b0, 5'd9, 32'h0BADC0DE, 5'd9, 5'd4, 2'd0, 1'b0, 16'h0);
      step();
      chk("R10", opnd_a, 32'hCAFEF00D);
      drive(1'b0, 5'd0, 32'h0, 5'd9, 5'd9, 2'd1, 1'b0, 16'h0);
      step();
      chk("R10", opnd_b, 32'hCAFEF00D);
      // R7: extreme immediates
      drive(1'b0, 5'd0, 32'h0, 5'd1, 5'd1, 2'd1, 1'b1, 16'hFFFF);
      step();
      chk("R7", opnd_b, 32'hFFFFFFFF);
      drive(1'b0, 5'd0, 32'h0, 5'd1, 5'd1, 2'd1, 1'b1, 16'h7FFF);
      step();
      chk("R7", opnd_b, 32'h00007FFF);

      // constrained random, biased towards address collisions
      for (int k = 0; k < 4000; k++) begin
         logic [4:0] wa = 5'($urandom_range(0, 31));
         logic [4:0] ra = ($urandom_range(0, 9) < 4) ? wa : 5'($urandom_range(0, 31));
         logic [4:0] rb = ($urandom_range(0, 9) < 3) ? wa : 5'($urandom_range(0, 31));
         drive($urandom_range(0, 3) != 0, wa, $urandom, ra, rb,
               2'($urandom_range(0, 3)), $urandom_range(0, 3) == 0,
               16'($urandom));
         step();
      end

      // R9: reset in the middle of traffic clears operands
      rst_n = 1'b0;
      #1;
      chk("R9", opnd_a, 32'h0);
      chk("R9", opnd_b, 32'h0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule